// File: doc/BRIEF.md
# Branch Target Address Calculator

This block works out where a jump or branch instruction sends the program counter. A decoder pulses `start_i` while it presents the instruction's own address, its length in bytes and one of four addressing forms. The operand bytes then arrive one per cycle on a byte stream qualified by `byte_valid_i`, in the order they sit in the instruction. The decoder can pause the stream for any number of idle cycles between bytes.

When the last operand byte arrives, the block registers the 16-bit target and raises `target_valid_o` for one cycle. From the cycle after `start_i`, it also drives the address of the next sequential instruction on `next_pc_o`. The four forms use different byte orders and offset signs:

- The two absolute forms are most-significant-byte first.
- The short relative form takes one signed byte.
- The long relative form takes an unsigned offset, least significant byte first.
- The 12-bit absolute form keeps the current 4 KiB segment.

Every relative distance is measured from the next instruction, not from the branch itself. Evaluating the branch condition, holding the PC and fetching instructions are left to the surrounding pipeline.

Top module: `brt_calc`

## Requirements
- R1: While reset is asserted and after its release, `target_valid_o` is 0, `target_o` is 0x0000 and `next_pc_o` is 0x0000 until the first `start_i`.
- R2: `start_i` latches `pc_i`, `len_i` (1 to 3) and `mode_i`, and discards any operand byte already collected. From the next cycle, `next_pc_o` equals the latched PC plus the latched length, and it holds that value until the next `start_i`.
- R3: Mode 0 (12-bit absolute) takes two bytes. The low nibble of the first byte gives target bits [11:8], the second byte gives bits [7:0], and the high nibble of the first byte is ignored. Bits [15:12] are copied from `next_pc_o`.
- R4: Mode 1 (16-bit absolute) takes two bytes. The first byte is target bits [15:8] and the second byte is bits [7:0].
- R5: Mode 2 (8-bit relative) takes one byte. The target is `next_pc_o` plus that byte sign-extended as two's complement.
- R6: Mode 3 (16-bit relative) takes two bytes. The target is `next_pc_o` plus the unsigned value {second byte, first byte}.
- R7: `target_valid_o` is 1 for exactly one cycle, in the cycle after the clock edge that captures the final expected byte. `target_o` changes only at that edge and otherwise holds its value.
- R8: These bytes are not captured and change neither `target_o` nor `target_valid_o`:
  - a byte with `byte_valid_i` low;
  - a byte presented in the same cycle as `start_i`;
  - a byte arriving after the final expected byte and before the next `start_i`;
  - a byte arriving before the first `start_i`.
- R9: Every address sum wraps modulo 2^16, both next-PC and relative target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new instruction; latch PC, length and mode |
| pc_i | input | 16 | Address of the branch instruction |
| len_i | input | 2 | Instruction length in bytes, 1 to 3 |
| mode_i | input | 2 | Addressing form: 0 abs12, 1 abs16, 2 rel8, 3 rel16 |
| byte_valid_i | input | 1 | Operand byte strobe |
| byte_i | input | 8 | Operand byte, in instruction order |
| target_o | output | 16 | Computed target address |
| next_pc_o | output | 16 | Address of the next sequential instruction |
| target_valid_o | output | 1 | One-cycle pulse: `target_o` is fresh |

## Verification
The bench drives the four forms with operand bytes chosen to separate them:

- First bytes with a nonzero high nibble show whether the 12-bit form masks it.
- Asymmetric byte pairs show whether the byte order is swapped between the absolute and long relative forms.
- Negative and positive short offsets show whether the sign is extended.

PCs near 0x0FFF and 0xFFFF show whether the segment bits come from the next address or from the instruction address, and whether the sums wrap. The byte stream is stretched with idle gaps, trailed by stray bytes, overlapped with `start_i` and cut short by a restart partway through an instruction. These patterns show whether capture counts only qualified bytes within one instruction.

// File: rtl/brt_pkg.sv
package brt_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2;
    localparam int SEG_W  = 12;

    typedef enum logic [1:0] {
        MODE_ABS12 = 2'd0,
        MODE_ABS16 = 2'd1,
        MODE_REL8  = 2'd2,
        MODE_REL16 = 2'd3
    } brt_mode_e;

    function automatic logic mode_needs_two(input brt_mode_e m);
        return (m != MODE_REL8);
    endfunction
endpackage

// File: rtl/brt_capture.sv
module brt_capture
    import brt_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          byte_valid_i,
    input  logic [BW-1:0] byte_i,
    input  logic          need_two_i,
    output logic [BW-1:0] first_o,
    output logic          final_o
);
    typedef struct packed {
        logic [BW-1:0] first;
        logic          have_one;
        logic          busy;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d    = st_q;
        take    = byte_valid_i && st_q.busy && !start_i;
        final_o = take && (!need_two_i || st_q.have_one);
        first_o = st_q.have_one ? st_q.first : byte_i;
        if (start_i) begin
            st_d.busy     = 1'b1;
            st_d.have_one = 1'b0;
            st_d.first    = '0;
        end else if (final_o) begin
            st_d.busy     = 1'b0;
            st_d.have_one = 1'b0;
        end else if (take) begin
            st_d.have_one = 1'b1;
            st_d.first    = byte_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/brt_target_calc.sv
module brt_target_calc
    import brt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int SW = SEG_W
) (
    input  brt_mode_e      mode_i,
    input  logic [AW-1:0]  next_pc_i,
    input  logic [BW-1:0]  first_i,
    input  logic [BW-1:0]  second_i,
    output logic [AW-1:0]  target_o
);
    localparam int HI_NIB = SW - BW;

    logic [AW-1:0] rel8_off;
    logic [AW-1:0] rel16_off;

    assign rel8_off  = {{(AW-BW){first_i[BW-1]}}, first_i};
    assign rel16_off = AW'({second_i, first_i});

    always_comb begin
        unique case (mode_i)
            MODE_ABS12: target_o = {next_pc_i[AW-1:SW], first_i[HI_NIB-1:0], second_i};
            MODE_ABS16: target_o = AW'({first_i, second_i});
            MODE_REL8:  target_o = next_pc_i + rel8_off;
            default:    target_o = next_pc_i + rel16_off;
        endcase
    end
endmodule

// File: rtl/brt_calc.sv
module brt_calc
    import brt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] pc_i,
    input  logic [LW-1:0] len_i,
    input  logic [1:0]    mode_i,
    input  logic          byte_valid_i,
    input  logic [BW-1:0] byte_i,
    output logic [AW-1:0] target_o,
    output logic [AW-1:0] next_pc_o,
    output logic          target_valid_o
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [LW-1:0] len;
        brt_mode_e     mode;
        logic [AW-1:0] tgt;
        logic          vld;
    } calc_st_t;

    calc_st_t      st_d, st_q;
    logic [BW-1:0] first_byte;
    logic          final_byte;
    logic [AW-1:0] nxt_pc;
    logic [AW-1:0] tgt_calc;
    brt_mode_e     mode_lat;

    assign nxt_pc   = st_q.pc + AW'(st_q.len);
    assign mode_lat = st_q.mode;

    brt_capture #(.BW(BW)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .need_two_i   (mode_needs_two(st_q.mode)),
        .first_o      (first_byte),
        .final_o      (final_byte)
    );

    brt_target_calc #(.AW(AW), .BW(BW)) u_tgt (
        .mode_i    (st_q.mode),
        .next_pc_i (nxt_pc),
        .first_i   (first_byte),
        .second_i  (byte_i),
        .target_o  (tgt_calc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start_i) begin
            st_d.pc   = pc_i;
            st_d.len  = len_i;
            st_d.mode = brt_mode_e'(mode_i);
        end else if (final_byte) begin
            st_d.tgt = tgt_calc;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign target_o       = st_q.tgt;
    assign next_pc_o      = nxt_pc;
    assign target_valid_o = st_q.vld;
endmodule

// File: rtl/brt_calc_chk.sv
module brt_calc_chk
    import brt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [15:0] pc_i,
    input logic [1:0]  len_i,
    input logic        byte_valid_i,
    input logic [7:0]  byte_i,
    input logic [15:0] target_o,
    input logic [15:0] next_pc_o,
    input logic        target_valid_o,
    input brt_mode_e   mode_lat
);
    // R2 R9
    next_pc_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> next_pc_o == 16'($past(pc_i) + 16'($past(len_i))));

    // R7
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target_valid_o |=> !target_valid_o);

    // R7
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !target_valid_o |-> $stable(target_o));

    // R8
    valid_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target_valid_o |-> ($past(byte_valid_i) && !$past(start_i)));

    // R3 R4
    abs_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_valid_o && (mode_lat == MODE_ABS12 || mode_lat == MODE_ABS16))
            |-> target_o[7:0] == $past(byte_i));

    // R3
    abs12_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_valid_o && mode_lat == MODE_ABS12) |-> target_o[15:12] == next_pc_o[15:12]);
endmodule

bind brt_calc brt_calc_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .pc_i           (pc_i),
    .len_i          (len_i),
    .byte_valid_i   (byte_valid_i),
    .byte_i         (byte_i),
    .target_o       (target_o),
    .next_pc_o      (next_pc_o),
    .target_valid_o (target_valid_o),
    .mode_lat       (mode_lat)
);

// File: tb/brt_calc_tb_top.sv
module brt_calc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [1:0]  len_i = '0;
    logic [1:0]  mode_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [15:0] target_o, next_pc_o;
    logic        target_valid_o;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    brt_calc dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .len_i(len_i),
        .mode_i(mode_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .target_o(target_o), .next_pc_o(next_pc_o), .target_valid_o(target_valid_o)
    );

    // Behavioural reference model
    int unsigned m_pc, m_len, m_mode, m_tgt;
    bit          m_busy, m_vld;
    int          q[$];

    function automatic int unsigned ref_target(int unsigned nx, int unsigned md, int b0, int b1);
        int off;
        case (md)
            0: return (nx & 32'hF000) | ((b0 & 15) * 256) | b1;
            1: return b0 * 256 + b1;
            2: begin off = (b0 >= 128) ? b0 - 256 : b0; return (nx + off) & 32'hFFFF; end
            default: return (nx + b1 * 256 + b0) & 32'hFFFF;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_len = 0; m_mode = 0; m_tgt = 0; m_busy = 0; m_vld = 0; q.delete();
        end else begin
            m_vld = 0;
            if (start_i) begin
                m_pc = pc_i; m_len = len_i; m_mode = mode_i; m_busy = 1; q.delete();
            end else if (byte_valid_i && m_busy) begin
                q.push_back(int'(byte_i));
                if (q.size() == ((m_mode == 2) ? 1 : 2)) begin
                    m_tgt = ref_target((m_pc + m_len) & 32'hFFFF, m_mode, q[0],
                                       (q.size() > 1) ? q[1] : 0);
                    m_vld = 1; m_busy = 0;
                end
            end
        end
    end

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({tag, " valid (R7)"}, target_valid_o, m_vld);
            check({tag, " next_pc (R2)"}, next_pc_o, (m_pc + m_len) & 32'hFFFF);
            check({tag, " target"}, target_o, m_tgt);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 0; byte_valid_i = 0; byte_i = 8'hEE;
        end
    endtask

    task automatic begin_instr(string t, int unsigned pc, int unsigned ln, int unsigned md, bit with_byte);
        @(negedge clk);
        tag = t;
        start_i = 1; pc_i = 16'(pc); len_i = 2'(ln); mode_i = 2'(md);
        byte_valid_i = with_byte; byte_i = 8'h5A;
    endtask

    task automatic send(int b, int gap);
        idle(gap);
        @(negedge clk);
        start_i = 0; byte_valid_i = 1; byte_i = 8'(b);
    endtask

    task automatic instr(string t, int unsigned pc, int unsigned ln, int unsigned md, int b0, int b1, int gap);
        begin_instr(t, pc, ln, md, 1'b0);
        send(b0, gap);
        if (md != 2) send(b1, gap);
        idle(2);
    endtask

    initial begin
        idle(3);
        // R1: outputs during reset
        check("R1 valid", target_valid_o, 0);
        check("R1 target", target_o, 0);
        check("R1 next_pc", next_pc_o, 0);
        rst_n = 1;
        tag = "R8 pre-start";
        send(8'h77, 0); send(8'h12, 0); idle(2);
        check("R1 target after reset", target_o, 0);
        check("R1 valid after reset", target_valid_o, 0);

        instr("R3 abs12", 16'h4100, 2, 0, 8'hF3, 8'h21, 0);
        check("R3 nibble mask", target_o, 16'h4321);
        instr("R3 abs12 straddle", 16'h0FFE, 3, 0, 8'h0A, 8'hBC, 1);
        check("R3 segment from next pc", target_o, 16'h1ABC);
        instr("R4 abs16", 16'h0123, 3, 1, 8'hBE, 8'hEF, 0);
        check("R4 big endian", target_o, 16'hBEEF);
        instr("R5 rel8 negative", 16'h1000, 2, 2, 8'hFE, 0, 0);
        check("R5 negative", target_o, 16'h1000);
        instr("R5 rel8 positive", 16'h2000, 2, 2, 8'h7F, 0, 3);
        check("R5 positive", target_o, 16'h2081);
        instr("R6 rel16", 16'h1000, 3, 3, 8'h34, 8'h12, 0);
        check("R6 little endian", target_o, 16'h2237);
        instr("R9 rel16 wrap", 16'hF000, 3, 3, 8'h00, 8'h20, 2);
        check("R9 wrap target", target_o, 16'h1003);
        begin_instr("R9 pc wrap", 16'hFFFF, 3, 2, 1'b0);
        idle(1);
        check("R9 next_pc wrap", next_pc_o, 16'h0002);
        send(8'h80, 0); idle(2);
        check("R9 rel8 wrap", target_o, 16'hFF82);

        // R8: byte alongside start, stray bytes afterwards
        begin_instr("R8 start+byte", 16'h0300, 2, 1, 1'b1);
        send(8'h11, 0); send(8'h22, 0); send(8'h33, 0); send(8'h44, 1); idle(2);
        check("R8 start byte dropped, trailing ignored", target_o, 16'h1122);
        // R2: restart mid-capture discards first byte
        begin_instr("R2 restart", 16'h0500, 2, 1, 1'b0);
        send(8'h99, 0);
        begin_instr("R2 restart", 16'h0600, 1, 3, 1'b0);
        send(8'h01, 1); send(8'h00, 0); idle(2);
        check("R2 restart target", target_o, 16'h0602);
        // back-to-back instructions
        instr("R7 back to back a", 16'h7000, 2, 2, 8'h10, 0, 0);
        instr("R7 back to back b", 16'h7000, 1, 0, 8'h0F, 8'hFF, 0);
        check("R7 held target", target_o, 16'h7FFF);
        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule